// File: doc/BRIEF.md
# Pipelined 5x5 Matrix Multiplier

This block multiplies two 5x5 signed integer matrices and produces the 25 elements of the product as a stream, one element per clock cycle once the pipeline is full. Each operand sits in a small wide-word memory. The left operand memory stores one full row per word. The right operand memory stores one full column per word. With that layout, one read from each memory supplies all five terms of one dot product in the same cycle. Five multipliers and a registered adder tree then form the element, and no partial sum is ever written back to storage.

Before a run, software or a neighbouring block fills both operand memories through their write ports. A one-cycle `start` with the block idle launches a run. The issue sequencer walks the 25 (row, column) pairs in row-major order, one pair per cycle. Each result appears exactly 10 cycles after its pair was issued, qualified by `res_valid` and tagged with its row and column. One cycle after the last element, `done` pulses.

The result stream has no ready input, so the consumer cannot apply back-pressure. The consumer must take every element in the cycle where `res_valid` is high. The fixed latency and the gapless 25-cycle burst are part of the contract. Each run therefore takes 35 cycles from the accepting edge to the `done` pulse.

Top module: `matmul5_pipe`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is asserted, `res_valid`, `done` and `busy` are all 0. A reset in the middle of a run cancels it, and no further results appear.
- R2: Each result equals the sum over k = 0..4 of A[i][k]*B[k][j]. Operands are 8-bit two's complement and results are 19-bit two's complement, with no overflow even when every operand is -128.
- R3: Word i of the A memory holds row i of A, and word j of the B memory holds column j of B. In both, element k occupies bits [8k+7:8k].
- R4: Results leave in row-major order, with the column varying fastest. `res_row` and `res_col` carry i and j of the element on `res_data`.
- R5: If `start` is sampled high at clock edge E while `busy` is low, `res_valid` is high after edges E+10 through E+34. That is 25 consecutive cycles, each element 10 cycles after its pair was issued.
- R6: `busy` is high after edges E through E+34. `done` is high for exactly one cycle, after edge E+35, which is the cycle after the last result. `busy` is low in that cycle.
- R7: A `start` sampled while `busy` is high is ignored. This includes a `start` at edge E+35. The ignored `start` adds no results and no second `done`.
- R8: If `start` is held high, a new run is accepted on the first edge at which `busy` is low (edge E+36). That run follows R5 and R6 counted from E+36.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run; taken only when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last result |
| a_we | input | 1 | Write enable, left operand memory |
| a_waddr | input | 3 | Row index to write |
| a_wdata | input | 40 | Packed row, element k at bits [8k+7:8k] |
| b_we | input | 1 | Write enable, right operand memory |
| b_waddr | input | 3 | Column index to write |
| b_wdata | input | 40 | Packed column, element k at bits [8k+7:8k] |
| res_valid | output | 1 | Result element present this cycle |
| res_row | output | 3 | Row index i of the result |
| res_col | output | 3 | Column index j of the result |
| res_data | output | 19 | Signed result element |

## Verification
The bench builds the block with its default parameters: five terms per dot product, 8-bit operands and a latency of 10. With five terms, the adder tree has an odd leaf count, so one level carries an element through unpaired. A latency of 10 leaves five padding stages after the tree. Operand patterns made entirely of -128, or of -128 against 127, push the 19-bit result to both ends of its range. The 36-cycle run length keeps the ignored start at edge E+35 and the held-start relaunch at E+36 cheap to reach in a few runs.

// File: rtl/mmul_pkg.sv
package mmul_pkg;

  // Number of pairwise adder levels needed to reduce n terms to one.
  function automatic int tree_levels(input int n);
    int lv;
    int cnt;
    lv  = 0;
    cnt = n;
    while (cnt > 1) begin
      cnt = (cnt + 1) / 2;
      lv++;
    end
    return lv;
  endfunction

endpackage

// File: rtl/mmul_opmem.sv
module mmul_opmem #(
  parameter int DEPTH = 5,
  parameter int WIDTH = 40,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  // One write port and one registered read port; a whole row or column per word.
  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) begin
      store[waddr] <= wdata;
    end
    rdata <= store[raddr];
  end

endmodule

// File: rtl/mmul_issue.sv
module mmul_issue #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          finish,
  output logic          busy,
  output logic          iss_valid,
  output logic [IW-1:0] iss_row,
  output logic [IW-1:0] iss_col
);

  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  logic accept;
  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      iss_valid <= 1'b0;
      iss_row   <= '0;
      iss_col   <= '0;
    end else begin
      if (accept) begin
        busy      <= 1'b1;
        iss_valid <= 1'b1;
        iss_row   <= '0;
        iss_col   <= '0;
      end else if (iss_valid) begin
        if (iss_col == LAST_IDX) begin
          iss_col <= '0;
          if (iss_row == LAST_IDX) begin
            iss_valid <= 1'b0;
          end else begin
            iss_row <= iss_row + 1'b1;
          end
        end else begin
          iss_col <= iss_col + 1'b1;
        end
      end
      if (finish) begin
        busy <= 1'b0;
      end
    end
  end

  AST_ISSUE_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !(iss_row == LAST_IDX && iss_col == LAST_IDX) |=> iss_valid); // R5
  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R7
  AST_ISSUE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_row <= LAST_IDX) && (iss_col <= LAST_IDX)); // R4

endmodule

// File: rtl/mmul_dotpipe.sv
module mmul_dotpipe #(
  parameter int N   = 5,
  parameter int EW  = 8,
  parameter int IW  = 3,
  parameter int LAT = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [IW-1:0]        in_row,
  input  logic [IW-1:0]        in_col,
  input  logic [N*EW-1:0]      row_word,
  input  logic [N*EW-1:0]      col_word,
  output logic                 out_valid,
  output logic [IW-1:0]        out_row,
  output logic [IW-1:0]        out_col,
  output logic signed [2*EW+mmul_pkg::tree_levels(N)-1:0] out_sum
);

  localparam int TL  = mmul_pkg::tree_levels(N);
  localparam int RW  = 2 * EW + TL;
  localparam int PW  = 2 * EW;
  // memory read + product register + TL tree levels, padded up to LAT
  localparam int PAD = LAT - 2 - TL;

  logic signed [EW-1:0] ea  [N];
  logic signed [EW-1:0] eb  [N];
  logic signed [PW-1:0] prd [N];

  always_comb begin
    for (int k = 0; k < N; k++) begin
      ea[k]  = row_word[k*EW +: EW];
      eb[k]  = col_word[k*EW +: EW];
      prd[k] = PW'(ea[k]) * PW'(eb[k]);
    end
  end

  // Level 0 holds the products; unused slots stay zero so odd counts pass through.
  logic signed [RW-1:0] lvl [TL+1][2*N];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 2 * N; k++) begin
      if (k < N) lvl[0][k] <= RW'(prd[k]);
      else       lvl[0][k] <= '0;
    end
    for (int l = 1; l <= TL; l++) begin
      for (int m = 0; m < 2 * N; m++) begin
        if (m < N) lvl[l][m] <= lvl[l-1][2*m] + lvl[l-1][2*m+1];
        else       lvl[l][m] <= '0;
      end
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      logic signed [RW-1:0] dly [PAD];
      always_ff @(posedge clk) begin
        dly[0] <= lvl[TL][0];
        for (int p = 1; p < PAD; p++) begin
          dly[p] <= dly[p-1];
        end
      end
      assign out_sum = dly[PAD-1];
    end else begin : g_nopad
      assign out_sum = lvl[TL][0];
    end
  endgenerate

  // Valid and indices travel alongside the data for exactly LAT cycles.
  logic          vsr [LAT];
  logic [IW-1:0] rsr [LAT];
  logic [IW-1:0] csr [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin
        vsr[s] <= 1'b0;
        rsr[s] <= '0;
        csr[s] <= '0;
      end
    end else begin
      vsr[0] <= in_valid;
      rsr[0] <= in_row;
      csr[0] <= in_col;
      for (int s = 1; s < LAT; s++) begin
        vsr[s] <= vsr[s-1];
        rsr[s] <= rsr[s-1];
        csr[s] <= csr[s-1];
      end
    end
  end

  assign out_valid = vsr[LAT-1];
  assign out_row   = rsr[LAT-1];
  assign out_col   = csr[LAT-1];

  AST_OUT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_row) < N) && (int'(out_col) < N)); // R4

endmodule

// File: rtl/matmul5_pipe.sv
module matmul5_pipe #(
  parameter int N   = 5,
  parameter int EW  = 8,
  parameter int LAT = 10,
  localparam int IW = $clog2(N),
  localparam int WW = N * EW,
  localparam int RW = 2 * EW + mmul_pkg::tree_levels(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic                 a_we,
  input  logic [IW-1:0]        a_waddr,
  input  logic [WW-1:0]        a_wdata,
  input  logic                 b_we,
  input  logic [IW-1:0]        b_waddr,
  input  logic [WW-1:0]        b_wdata,
  output logic                 res_valid,
  output logic [IW-1:0]        res_row,
  output logic [IW-1:0]        res_col,
  output logic signed [RW-1:0] res_data
);

  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);
  localparam int            CW       = $clog2(LAT + 2) + 1;

  logic          iss_valid;
  logic [IW-1:0] iss_row;
  logic [IW-1:0] iss_col;
  logic [WW-1:0] a_row_word;
  logic [WW-1:0] b_col_word;
  logic          last_out;

  assign last_out = res_valid && (res_row == LAST_IDX) && (res_col == LAST_IDX);

  mmul_issue #(.N(N), .IW(IW)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .finish    (last_out),
    .busy      (busy),
    .iss_valid (iss_valid),
    .iss_row   (iss_row),
    .iss_col   (iss_col)
  );

  mmul_opmem #(.DEPTH(N), .WIDTH(WW), .AW(IW)) u_amem (
    .clk   (clk),
    .we    (a_we),
    .waddr (a_waddr),
    .wdata (a_wdata),
    .raddr (iss_row),
    .rdata (a_row_word)
  );

  mmul_opmem #(.DEPTH(N), .WIDTH(WW), .AW(IW)) u_bmem (
    .clk   (clk),
    .we    (b_we),
    .waddr (b_waddr),
    .wdata (b_wdata),
    .raddr (iss_col),
    .rdata (b_col_word)
  );

  mmul_dotpipe #(.N(N), .EW(EW), .IW(IW), .LAT(LAT)) u_dot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (iss_valid),
    .in_row    (iss_row),
    .in_col    (iss_col),
    .row_word  (a_row_word),
    .col_word  (b_col_word),
    .out_valid (res_valid),
    .out_row   (res_row),
    .out_col   (res_col),
    .out_sum   (res_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= last_out;
  end

  // Cycles since the last accepted start, saturating; used by the checks below.
  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                run_cnt <= '1;
    else if (start && !busy)   run_cnt <= '0;
    else if (run_cnt != '1)    run_cnt <= run_cnt + 1'b1;
  end

  AST_FIRST_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_row == '0 && res_col == '0 |-> int'(run_cnt) == LAT); // R5
  AST_STREAM_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !last_out |=> res_valid); // R5
  AST_COL_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_col != LAST_IDX |=> res_col == $past(res_col) + 1'b1 && res_row == $past(res_row)); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_out |=> done && !busy); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: tb/sim_matmul5_pipe.sv
`timescale 1ns/1ps
module sim_matmul5_pipe;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        busy;
  logic        done;
  logic        a_we, b_we;
  logic [2:0]  a_waddr, b_waddr;
  logic [39:0] a_wdata, b_wdata;
  logic        res_valid;
  logic [2:0]  res_row, res_col;
  logic signed [18:0] res_data;

  int n_chk = 0;
  int n_bad = 0;
  int ra [5][5];
  int rb [5][5];
  int rc [5][5];

  // columns: A pattern, B pattern, seed, expected C[0][0]
  localparam int NCASE = 5;
  localparam int TAB [NCASE][4] = '{
    '{0, 4, 0,    -12},
    '{1, 1, 0,  81920},
    '{1, 2, 0, -81280},
    '{3, 3, 11, -6585},
    '{4, 3, 5,  -3120}
  };

  always #10 clk = ~clk;

  matmul5_pipe u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .a_we(a_we), .a_waddr(a_waddr), .a_wdata(a_wdata),
    .b_we(b_we), .b_waddr(b_waddr), .b_wdata(b_wdata),
    .res_valid(res_valid), .res_row(res_row), .res_col(res_col), .res_data(res_data)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int elem(input int pat, input int seed, input int r, input int c);
    case (pat)
      0:       return (r == c) ? 1 : 0;
      1:       return -128;
      2:       return 127;
      3:       return ((r * 7 + c * 13 + seed) * 37 % 256) - 128;
      default: return r * 5 + c - 12;
    endcase
  endfunction

  // R3: row i of A goes to A word i, column j of B goes to B word j, element k at [8k+7:8k]
  task automatic load(input int pa, input int pb, input int seed);
    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < 5; c++) begin
        ra[r][c] = elem(pa, seed, r, c);
        rb[r][c] = elem(pb, seed, r, c);
      end
    end
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        rc[i][j] = 0;
        for (int k = 0; k < 5; k++) rc[i][j] += ra[i][k] * rb[k][j];
      end
    end
    for (int w = 0; w < 5; w++) begin
      a_we = 1'b1; b_we = 1'b1;
      a_waddr = 3'(w); b_waddr = 3'(w);
      for (int k = 0; k < 5; k++) begin
        a_wdata[k*8 +: 8] = 8'(ra[w][k]);
        b_wdata[k*8 +: 8] = 8'(rb[k][w]);
      end
      @(negedge clk);
    end
    a_we = 1'b0; b_we = 1'b0;
  endtask

  // Launch a run and follow it cycle by cycle. c counts negedges after the accepting edge.
  task automatic run(input string req, input int ign_at, input bit hold, input int corner);
    int last_c;
    int base2;
    start = 1'b1;
    @(negedge clk);
    last_c = hold ? 72 : 37;
    base2  = hold ? 36 : -1000;
    for (int c = 0; c <= last_c; c++) begin
      bit ev, ed, eb;
      int er, ek, d;
      ev = 0; ed = 0; eb = 0; er = 0; ek = 0;
      for (int b = 0; b < 2; b++) begin
        d = c - ((b == 0) ? 0 : base2);
        if (d >= 10 && d <= 34) begin ev = 1; er = (d - 10) / 5; ek = (d - 10) % 5; end
        if (d == 35) ed = 1;
        if (d >= 0 && d <= 34) eb = 1;
      end
      check(res_valid === ev, req, $sformatf("res_valid c=%0d", c), int'(res_valid), int'(ev));
      check(done === ed, (req == "R5") ? "R6" : req, $sformatf("done c=%0d", c), int'(done), int'(ed));
      check(busy === eb, (req == "R5") ? "R6" : req, $sformatf("busy c=%0d", c), int'(busy), int'(eb));
      if (ev && res_valid === 1'b1) begin
        check(int'(res_row) == er && int'(res_col) == ek, "R4", "index",
              int'(res_row) * 10 + int'(res_col), er * 10 + ek);
        check(int'(res_data) == rc[er][ek], "R2", $sformatf("C[%0d][%0d]", er, ek),
              int'(res_data), rc[er][ek]);
        if (er == 0 && ek == 0 && c == 10)
          check(int'(res_data) == corner, "R3", "table C[0][0]", int'(res_data), corner);
      end
      start = hold ? (c < 36) : (c + 1 == ign_at);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    a_we = 1'b0; b_we = 1'b0; a_waddr = '0; b_waddr = '0; a_wdata = '0; b_wdata = '0;
    repeat (3) @(negedge clk);
    check(res_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "R1", "outputs in reset",
          int'(res_valid) + int'(done) + int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "R1", "outputs after reset",
          int'(res_valid) + int'(done) + int'(busy), 0);

    // Table walk: R2, R3, R4, R5, R6
    for (int t = 0; t < NCASE; t++) begin
      load(TAB[t][0], TAB[t][1], TAB[t][2]);
      run("R5", 0, 1'b0, TAB[t][3]);
    end

    // R7: start while busy, mid-run and at the done edge
    load(3, 3, 11);
    run("R7", 5, 1'b0, -6585);
    run("R7", 35, 1'b0, -6585);

    // R8: start held high relaunches right after done
    load(4, 3, 5);
    run("R8", 0, 1'b1, -3120);

    // R1: reset in the middle of a run
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (14) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(res_valid === 1'b0 && done === 1'b0 && busy === 1'b0, "R1", "mid-run reset",
          int'(res_valid) + int'(done) + int'(busy), 0);
    rst_n = 1'b1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      check(res_valid === 1'b0 && done === 1'b0, "R1", $sformatf("quiet after reset c=%0d", c),
            int'(res_valid) + int'(done), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule